// File: doc/BRIEF.md
# Sign-Case Interval Multiplier

This block multiplies two closed intervals whose endpoints are 16-bit two's complement numbers and returns the enclosing product interval with 32-bit endpoints. Each operand is first sorted into one of three sign classes: entirely at or above zero, entirely at or below zero, or spanning zero. The pair of classes forms a 4-bit case code. That code picks which of the four endpoint products becomes each bound of the result, so most cases need no comparison at all.

When both operands span zero, each bound has two possible products. Those candidates are held for one cycle in a delay register, and then a comparator picks the minimum and the maximum. That case therefore takes one cycle longer than the others. While it is pending, a busy output is high and the block accepts no new operation.

A caller drives the four bounds together with a one-cycle start strobe. It then waits for a one-cycle valid pulse and reads the bounds and the case code.

Top module: `ivmul_top`

## Requirements
- R1: The case code reported with each result is built from the sign classes of X (rows) and Y (columns). X at or above zero gives 0001, 0010 and 0011 for Y at or above zero, Y spanning zero and Y at or below zero. X spanning zero gives 0100, 0000 and 0101 for the same three classes of Y. X at or below zero gives 0110, 0111 and 1000.
- R2: An operand whose lower bound is at least zero is in the at-or-above class. Otherwise, an operand whose upper bound is at most zero is in the at-or-below class. Otherwise it spans zero. So a [0,0] operand counts as at-or-above zero.
- R3: For every case other than 0000, the result is one endpoint product per bound. 0001 gives [xL·yL, xU·yU]. 0010 gives [xU·yL, xU·yU]. 0011 gives [xU·yL, xL·yU]. 0100 gives [xL·yU, xU·yU]. 0101 gives [xU·yL, xL·yL]. 0110 gives [xL·yU, xU·yL]. 0111 gives [xL·yU, xL·yL]. 1000 gives [xU·yU, xL·yL]. Each product is a full signed 32-bit product.
- R4: In case 0000, the lower bound is min(xL·yU, xU·yL) and the upper bound is max(xL·yL, xU·yU).
- R5: When start is sampled high while the block is not busy and the case is not 0000, valid is high in the next cycle and carries that result.
- R6: When start is sampled high while the block is not busy and the case is 0000, busy is high and valid is low in the next cycle. Valid is high with the result in the cycle after that.
- R7: A start sampled while busy is high is ignored. It produces no result of its own and does not alter the pending result.
- R8: Valid is a single-cycle pulse for each accepted operation. The result outputs hold their last value until the next result.
- R9: After reset, valid, busy, both bounds and the case code are all zero.
- R10: For well-formed operands (lower bound not above upper bound), the reported lower bound never exceeds the reported upper bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation strobe, sampled with the operands |
| x_lo | input | 16 | Lower bound of X |
| x_hi | input | 16 | Upper bound of X |
| y_lo | input | 16 | Lower bound of Y |
| y_hi | input | 16 | Upper bound of Y |
| z_lo | output | 32 | Lower bound of the product |
| z_hi | output | 32 | Upper bound of the product |
| case_flag | output | 4 | Sign case code of the result |
| valid | output | 1 | Result valid, one-cycle pulse |
| busy | output | 1 | Both-span result pending; start ignored |

## Verification
One pair of events can fall in the same cycle: a both-span operation finishing out of its delay stage, and a fresh start strobe arriving at that same edge. The bench keeps start high during the busy cycle and changes the operands to a fast, single-cycle case. It then expects the both-span result with code 0000 to appear. It also expects no second valid pulse in the following cycle. Random operand pairs, biased toward small values and zero endpoints, are judged against the minimum and maximum of all four endpoint products. This reference is an independent way to arrive at the same bounds as the case table.

// File: rtl/ivmul_pkg.sv
package ivmul_pkg;

  typedef enum logic [1:0] {
    SGN_POS  = 2'd0,
    SGN_SPAN = 2'd1,
    SGN_NEG  = 2'd2
  } sgn_t;

  localparam logic [3:0] CASE_SPAN2 = 4'b0000;

  // pair of operand classes -> case code
  function automatic logic [3:0] case_code(input sgn_t xs, input sgn_t ys);
    logic [3:0] c;
    unique case (xs)
      SGN_POS:  c = (ys == SGN_POS) ? 4'b0001 : (ys == SGN_SPAN) ? 4'b0010 : 4'b0011;
      SGN_SPAN: c = (ys == SGN_POS) ? 4'b0100 : (ys == SGN_SPAN) ? 4'b0000 : 4'b0101;
      default:  c = (ys == SGN_POS) ? 4'b0110 : (ys == SGN_SPAN) ? 4'b0111 : 4'b1000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ivmul_classify.sv
module ivmul_classify
  import ivmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] x_lo,
  input  logic signed [W-1:0] x_hi,
  input  logic signed [W-1:0] y_lo,
  input  logic signed [W-1:0] y_hi,
  output logic [3:0]          flag
);

  // lower bound at/above zero wins, then upper bound at/below zero
  function automatic sgn_t sign_class(input logic signed [W-1:0] lo,
                                      input logic signed [W-1:0] hi);
    if (!lo[W-1])                    return SGN_POS;
    else if (hi[W-1] || (hi == '0))  return SGN_NEG;
    else                             return SGN_SPAN;
  endfunction

  sgn_t x_cls, y_cls;

  always_comb begin
    x_cls = sign_class(x_lo, x_hi);
    y_cls = sign_class(y_lo, y_hi);
    flag  = case_code(x_cls, y_cls);
  end

endmodule

// File: rtl/ivmul_products.sv
module ivmul_products #(
  parameter int W  = 16,
  localparam int PW = 2 * W
) (
  input  logic signed [W-1:0] x_lo,
  input  logic signed [W-1:0] x_hi,
  input  logic signed [W-1:0] y_lo,
  input  logic signed [W-1:0] y_hi,
  // index 0: xL*yL, 1: xL*yU, 2: xU*yL, 3: xU*yU
  output logic [3:0][PW-1:0]  prod
);

  function automatic logic [PW-1:0] smul(input logic signed [W-1:0] a,
                                         input logic signed [W-1:0] b);
    logic signed [PW-1:0] ae, be;
    ae = {{W{a[W-1]}}, a};
    be = {{W{b[W-1]}}, b};
    return ae * be;
  endfunction

  for (genvar i = 0; i < 4; i++) begin : g_mul
    logic signed [W-1:0] opa, opb;
    assign opa = (i < 2)       ? x_lo : x_hi;
    assign opb = ((i % 2) == 0) ? y_lo : y_hi;
    assign prod[i] = smul(opa, opb);
  end

endmodule

// File: rtl/ivmul_select.sv
module ivmul_select #(
  parameter int W  = 16,
  localparam int PW = 2 * W
) (
  input  logic [3:0]          flag,
  input  logic [3:0][PW-1:0]  prod,
  output logic [PW-1:0]       sel_lo,
  output logic [PW-1:0]       sel_hi
);

  localparam int LL = 0, LU = 1, UL = 2, UU = 3;

  always_comb begin
    sel_lo = prod[LL];
    sel_hi = prod[UU];
    unique case (flag)
      4'b0001: begin sel_lo = prod[LL]; sel_hi = prod[UU]; end
      4'b0010: begin sel_lo = prod[UL]; sel_hi = prod[UU]; end
      4'b0011: begin sel_lo = prod[UL]; sel_hi = prod[LU]; end
      4'b0100: begin sel_lo = prod[LU]; sel_hi = prod[UU]; end
      4'b0101: begin sel_lo = prod[UL]; sel_hi = prod[LL]; end
      4'b0110: begin sel_lo = prod[LU]; sel_hi = prod[UL]; end
      4'b0111: begin sel_lo = prod[LU]; sel_hi = prod[LL]; end
      4'b1000: begin sel_lo = prod[UU]; sel_hi = prod[LL]; end
      default: begin sel_lo = prod[LL]; sel_hi = prod[UU]; end
    endcase
  end

endmodule

// File: rtl/ivmul_top.sv
module ivmul_top
  import ivmul_pkg::*;
#(
  parameter int W  = 16,
  localparam int PW = 2 * W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [W-1:0]  x_lo,
  input  logic signed [W-1:0]  x_hi,
  input  logic signed [W-1:0]  y_lo,
  input  logic signed [W-1:0]  y_hi,
  output logic [PW-1:0]        z_lo,
  output logic [PW-1:0]        z_hi,
  output logic [3:0]           case_flag,
  output logic                 valid,
  output logic                 busy
);

  function automatic logic [PW-1:0] smin(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return ($signed(a) < $signed(b)) ? a : b;
  endfunction

  function automatic logic [PW-1:0] smax(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return ($signed(a) > $signed(b)) ? a : b;
  endfunction

  logic [3:0]          case_comb;
  logic [3:0][PW-1:0]  prod;
  logic [PW-1:0]       sel_lo, sel_hi;
  logic                accept, special_now;
  // delay stage for the both-span candidates
  logic [PW-1:0]       d_lo_a, d_lo_b, d_hi_a, d_hi_b;

  ivmul_classify #(.W(W)) u_cls (
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi), .flag(case_comb)
  );

  ivmul_products #(.W(W)) u_prod (
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi), .prod(prod)
  );

  ivmul_select #(.W(W)) u_sel (
    .flag(case_comb), .prod(prod), .sel_lo(sel_lo), .sel_hi(sel_hi)
  );

  assign accept      = start && !busy;
  assign special_now = (case_comb == CASE_SPAN2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_lo_a <= '0;
      d_lo_b <= '0;
      d_hi_a <= '0;
      d_hi_b <= '0;
    end else if (accept && special_now) begin
      d_lo_a <= prod[1];
      d_lo_b <= prod[2];
      d_hi_a <= prod[0];
      d_hi_b <= prod[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_lo      <= '0;
      z_hi      <= '0;
      case_flag <= '0;
      valid     <= 1'b0;
      busy      <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (busy) begin
        busy      <= 1'b0;
        valid     <= 1'b1;
        z_lo      <= smin(d_lo_a, d_lo_b);
        z_hi      <= smax(d_hi_a, d_hi_b);
        case_flag <= CASE_SPAN2;
      end else if (start) begin
        if (special_now) begin
          busy <= 1'b1;
        end else begin
          valid     <= 1'b1;
          z_lo      <= sel_lo;
          z_hi      <= sel_hi;
          case_flag <= case_comb;
        end
      end
    end
  end

endmodule

// File: rtl/ivmul_chk.sv
module ivmul_chk #(
  parameter int W  = 16,
  localparam int PW = 2 * W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          accept,
  input logic          special_now,
  input logic          busy,
  input logic          valid,
  input logic [3:0]    case_flag,
  input logic [PW-1:0] z_lo,
  input logic [PW-1:0] z_hi
);

  p_flag_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> case_flag <= 4'd8);

  p_fast_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !special_now) |=> (valid && !busy));

  p_span_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && special_now) |=> (busy && !valid));

  p_span_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (valid && !busy && case_flag == 4'b0000));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ##1 !valid || $past(accept, 1));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !busy) |=> ($stable(z_lo) && $stable(z_hi) && !valid));

  p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($signed(z_lo) <= $signed(z_hi)));

endmodule

bind ivmul_top ivmul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
  .special_now(special_now), .busy(busy), .valid(valid),
  .case_flag(case_flag), .z_lo(z_lo), .z_hi(z_hi)
);

// File: tb/tb_ivmul_top.sv
module tb_ivmul_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] x_lo = '0, x_hi = '0, y_lo = '0, y_hi = '0;
  logic [31:0] z_lo, z_hi;
  logic [3:0]  case_flag;
  logic valid, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ivmul_top dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi),
    .z_lo(z_lo), .z_hi(z_hi), .case_flag(case_flag),
    .valid(valid), .busy(busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0: at/above zero, 1: spans, 2: at/below zero
  function automatic int cls(input int lo, input int hi);
    if (lo >= 0) return 0;
    if (hi <= 0) return 2;
    return 1;
  endfunction

  function automatic int exp_flag(input int xl, xh, yl, yh);
    int idx;
    idx = cls(xl, xh) * 3 + cls(yl, yh);
    case (idx)
      0: return 1; 1: return 2; 2: return 3;
      3: return 4; 4: return 0; 5: return 5;
      6: return 6; 7: return 7; default: return 8;
    endcase
  endfunction

  // interval product = hull of the four endpoint products
  function automatic longint exp_lo(input int xl, xh, yl, yh);
    longint p [4];
    longint m;
    p = '{longint'(xl) * yl, longint'(xl) * yh, longint'(xh) * yl, longint'(xh) * yh};
    m = p[0];
    foreach (p[i]) if (p[i] < m) m = p[i];
    return m;
  endfunction

  function automatic longint exp_hi(input int xl, xh, yl, yh);
    longint p [4];
    longint m;
    p = '{longint'(xl) * yl, longint'(xl) * yh, longint'(xh) * yl, longint'(xh) * yh};
    m = p[0];
    foreach (p[i]) if (p[i] > m) m = p[i];
    return m;
  endfunction

  task automatic run_op(input int xl, xh, yl, yh);
    int f;
    f = exp_flag(xl, xh, yl, yh);
    @(negedge clk);
    x_lo = 16'(xl); x_hi = 16'(xh); y_lo = 16'(yl); y_hi = 16'(yh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (f == 0) begin
      chk("R6 busy", busy, 1);
      chk("R6 valid early", valid, 0);
      @(negedge clk);
      chk("R6 valid", valid, 1);
      chk("R4 lower", longint'($signed(z_lo)), exp_lo(xl, xh, yl, yh));
      chk("R4 upper", longint'($signed(z_hi)), exp_hi(xl, xh, yl, yh));
    end else begin
      chk("R5 valid", valid, 1);
      chk("R3 lower", longint'($signed(z_lo)), exp_lo(xl, xh, yl, yh));
      chk("R3 upper", longint'($signed(z_hi)), exp_hi(xl, xh, yl, yh));
    end
    chk("R1 flag", case_flag, f);
    chk("R10 order", longint'($signed(z_lo)) <= longint'($signed(z_hi)), 1);
  endtask

  function automatic int rnd16(input int mode);
    int v;
    v = int'($signed(16'($urandom)));
    if (mode == 0) v = v % 9;
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    longint hold_lo, hold_hi;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 valid", valid, 0);
    chk("R9 busy", busy, 0);
    chk("R9 z_lo", z_lo, 0);
    chk("R9 z_hi", z_hi, 0);
    chk("R9 flag", case_flag, 0);
    rst_n = 1'b1;

    // R2: zero-valued bounds
    run_op(0, 0, -3, 5);          // X counts as at/above zero -> 0010
    run_op(-5, 0, 0, 7);          // X at/below, Y at/above -> 0110
    run_op(-4, 3, -2, 0);         // X spans, Y at/below -> 0101
    run_op(0, 6, -9, 0);          // 0011
    // R3: each fast case
    run_op(2, 5, 3, 7);
    run_op(-6, -1, -4, 3);
    run_op(-8, -2, -7, -1);
    run_op(-32768, -32768, -32768, -32768);
    // R4: both span, including extremes
    run_op(-3, 4, -5, 2);
    run_op(-32768, 32767, -32768, 32767);
    run_op(-1, 1, -1, 1);

    // R7: start held high through the busy cycle with new operands
    @(negedge clk);
    x_lo = -7; x_hi = 2; y_lo = -3; y_hi = 9; start = 1'b1;
    @(negedge clk);
    chk("R7 busy", busy, 1);
    x_lo = 1; x_hi = 2; y_lo = 1; y_hi = 2;
    @(negedge clk);
    start = 1'b0;
    chk("R7 valid", valid, 1);
    chk("R7 flag", case_flag, 0);
    chk("R7 lower", longint'($signed(z_lo)), exp_lo(-7, 2, -3, 9));
    chk("R7 upper", longint'($signed(z_hi)), exp_hi(-7, 2, -3, 9));
    hold_lo = longint'($signed(z_lo));
    hold_hi = longint'($signed(z_hi));
    @(negedge clk);
    chk("R7 no second result", valid, 0);
    chk("R8 hold lower", longint'($signed(z_lo)), hold_lo);
    chk("R8 hold upper", longint'($signed(z_hi)), hold_hi);

    // random operands
    for (int n = 0; n < 300; n++) begin
      int a, b, c, d, m;
      m = int'($urandom_range(0, 1));
      a = rnd16(m); b = rnd16(m); c = rnd16(m); d = rnd16(m);
      if (a > b) begin int t; t = a; a = b; b = t; end
      if (c > d) begin int t; t = c; c = d; d = t; end
      run_op(a, b, c, d);
    end

    @(negedge clk);
    chk("R8 single pulse", valid, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule